// File: doc/BRIEF.md
# Sixteen-Bit Multi-Cycle RISC Core

This block is a small in-order processor core. It runs a twelve-instruction, sixteen-bit instruction set on eight sixteen-bit general registers. It has two separate memory ports, one for instructions and one for data. Each instruction passes through a short sequence of named states. The core first requests the instruction word and holds that request until it is acknowledged. It then decodes the word and either finishes it in one cycle (register, immediate, branch and jump operations) or moves on to a data access. A load takes one further cycle to write its result back to the register file.

Both ports carry a sixteen-bit byte address and a sixteen-bit data word. The memories on the far side are little-endian: bits 7:0 of a word hold the byte at the given address and bits 15:8 hold the byte at the next address. A request stays high, with its address and data steady, until the memory raises its acknowledge for one cycle. The core never requests on both ports at once.

States: `ST_FETCH` (instruction request outstanding), `ST_EXEC` (decode, ALU, branch resolution), `ST_MEM` (data request outstanding), `ST_WBACK` (load result written). Transitions: `ST_FETCH` to `ST_EXEC` on instruction acknowledge. `ST_EXEC` to `ST_MEM` for a load or store, otherwise back to `ST_FETCH`. `ST_MEM` to `ST_FETCH` when a store is acknowledged, and to `ST_WBACK` when a load is acknowledged. `ST_WBACK` always returns to `ST_FETCH`. Reset places the core in `ST_FETCH`.

Top module: `rc16_core`

## Requirements
- R1: While reset is low and right after it is released, the core is in the fetch state: it requests the instruction port at address 0, does not request the data port, and all eight registers read as zero.
- R2: An instruction request stays high with a constant address until acknowledged, and the two ports are never requested in the same cycle.
- R3: Register-register instructions (bits 15:12 opcode, 11:9 Rx, 8:6 Ry) compute Rx := Ry for opcode 0, Rx+Ry for 1, Rx-Ry for 2, Rx|Ry for 3 and Rx&Ry for 4, modulo 2^16.
- R4: Immediate instructions use bits 8:0 as a two's-complement value sign-extended to 16 bits. They compute Rx := imm for opcode 5, Rx+imm for 6 and Rx-imm for 7.
- R5: A load (opcode 8) or store (opcode 9) uses the byte address Ry + sext(bits 5:0). A store drives Rx on the write data with the write enable high. A load writes the acknowledged read word to Rx, and the next fetch starts two cycles after the acknowledge. Bits 7:0 of the word belong to the addressed byte, including at odd addresses.
- R6: A data request keeps its address, write enable and write data constant until acknowledged.
- R7: A branch (opcode 10) goes to PC+2+(sext(bits 5:0)<<1) when Rx is zero and to PC+2 otherwise. Ry plays no part in the test.
- R8: A jump (opcode 11) loads PC with bits 11:0 shifted left by one and zero-extended.
- R9: Opcodes 12 to 15 change no register and advance the PC by 2.
- R10: Every other instruction advances the PC by 2, and every fetch address is even.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_req | output | 1 | Instruction fetch request |
| imem_addr | output | 16 | Instruction byte address |
| imem_ack | input | 1 | Instruction request acknowledged, rdata valid |
| imem_rdata | input | 16 | Instruction word |
| dmem_req | output | 1 | Data access request |
| dmem_we | output | 1 | 1 = store, 0 = load |
| dmem_addr | output | 16 | Data byte address |
| dmem_wdata | output | 16 | Store data |
| dmem_ack | input | 1 | Data request acknowledged, rdata valid on loads |
| dmem_rdata | input | 16 | Load data |

## Verification
A wrong program counter appears on the very next fetch request, one or two cycles after the offending instruction, as an address that differs from the instruction-set model. A corrupted register or a faulty ALU result stays hidden until a store or a branch consumes it. For that reason every generated program ends with a store of each register, so any register error reaches the data port before the run halts. A state machine that drops a request before its acknowledge, or asks on both ports at once, is visible in the same cycle.

// File: rtl/rc16_pkg.sv
package rc16_pkg;

    localparam int WORD  = 16;
    localparam int NREGS = 8;
    localparam int RIDX  = $clog2(NREGS);

    typedef enum logic [3:0] {
        OP_MOV  = 4'd0,  OP_ADD  = 4'd1,  OP_SUB  = 4'd2,  OP_OR   = 4'd3,
        OP_AND  = 4'd4,  OP_MOVI = 4'd5,  OP_ADDI = 4'd6,  OP_SUBI = 4'd7,
        OP_LW   = 4'd8,  OP_SW   = 4'd9,  OP_BEZ  = 4'd10, OP_JUMP = 4'd11
    } op_e;

    typedef enum logic [2:0] {
        ALU_PASSB, ALU_ADD, ALU_SUB, ALU_OR, ALU_AND
    } alu_e;

    typedef enum logic [1:0] {
        ST_FETCH, ST_EXEC, ST_MEM, ST_WBACK
    } state_e;

    typedef struct packed {
        alu_e             aop;
        logic             imm_b;
        logic             wr;
        logic             ld;
        logic             st;
        logic             bez;
        logic             jmp;
        logic [RIDX-1:0]  rx;
        logic [RIDX-1:0]  ry;
        logic [WORD-1:0]  imm;
    } dec_t;

endpackage

// File: rtl/rc16_decode.sv
module rc16_decode
    import rc16_pkg::*;
(
    input  logic [WORD-1:0] instr,
    output dec_t            dec
);
    op_e             op;
    logic [WORD-1:0] sx6;
    logic [WORD-1:0] sx9;

    assign op  = op_e'(instr[15:12]);
    assign sx6 = {{(WORD-6){instr[5]}}, instr[5:0]};
    assign sx9 = {{(WORD-9){instr[8]}}, instr[8:0]};

    always_comb begin
        dec     = '0;
        dec.aop = ALU_PASSB;
        dec.rx  = instr[11:9];
        dec.ry  = instr[8:6];
        unique case (op)
            OP_MOV:  dec.wr = 1'b1;
            OP_ADD:  begin dec.wr = 1'b1; dec.aop = ALU_ADD; end
            OP_SUB:  begin dec.wr = 1'b1; dec.aop = ALU_SUB; end
            OP_OR:   begin dec.wr = 1'b1; dec.aop = ALU_OR;  end
            OP_AND:  begin dec.wr = 1'b1; dec.aop = ALU_AND; end
            OP_MOVI: begin dec.wr = 1'b1; dec.imm_b = 1'b1; dec.imm = sx9; end
            OP_ADDI: begin dec.wr = 1'b1; dec.imm_b = 1'b1; dec.imm = sx9; dec.aop = ALU_ADD; end
            OP_SUBI: begin dec.wr = 1'b1; dec.imm_b = 1'b1; dec.imm = sx9; dec.aop = ALU_SUB; end
            OP_LW:   begin dec.ld  = 1'b1; dec.imm = sx6; end
            OP_SW:   begin dec.st  = 1'b1; dec.imm = sx6; end
            OP_BEZ:  begin dec.bez = 1'b1; dec.imm = sx6; end
            OP_JUMP: dec.jmp = 1'b1;
            default: dec.wr = 1'b0;
        endcase
    end
endmodule

// File: rtl/rc16_regfile.sv
module rc16_regfile #(
    parameter int W = 16,
    parameter int N = 8,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic [AW-1:0] ra0,
    output logic [W-1:0]  rd0,
    input  logic [AW-1:0] ra1,
    output logic [W-1:0]  rd1
);
    logic [W-1:0] regs [N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) regs[i] <= '0;
        end else if (we) begin
            regs[wa] <= wd;
        end
    end

    assign rd0 = regs[ra0];
    assign rd1 = regs[ra1];
endmodule

// File: rtl/rc16_alu.sv
module rc16_alu
    import rc16_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_e         aop,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (aop)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_OR:  y = a | b;
            ALU_AND: y = a & b;
            default: y = b;
        endcase
    end
endmodule

// File: rtl/rc16_core.sv
module rc16_core
    import rc16_pkg::*;
#(
    parameter int W    = WORD,
    parameter int NREG = NREGS
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic         imem_req,
    output logic [W-1:0] imem_addr,
    input  logic         imem_ack,
    input  logic [W-1:0] imem_rdata,
    output logic         dmem_req,
    output logic         dmem_we,
    output logic [W-1:0] dmem_addr,
    output logic [W-1:0] dmem_wdata,
    input  logic         dmem_ack,
    input  logic [W-1:0] dmem_rdata
);
    localparam int RIX = $clog2(NREG);

    state_e        state_q, state_d;
    logic [W-1:0]  pc_q, ir_q, mdr_q;
    dec_t          dec;
    logic [W-1:0]  rx_val, ry_val, alu_b, alu_y, eff_addr;
    logic [W-1:0]  pc_inc, br_tgt, jmp_tgt, pc_exec;
    logic          rf_we;
    logic [W-1:0]  rf_wd;

    rc16_decode u_dec (.instr(ir_q), .dec(dec));

    rc16_regfile #(.W(W), .N(NREG)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .we(rf_we), .wa(dec.rx[RIX-1:0]), .wd(rf_wd),
        .ra0(dec.rx[RIX-1:0]), .rd0(rx_val),
        .ra1(dec.ry[RIX-1:0]), .rd1(ry_val)
    );

    assign alu_b = dec.imm_b ? dec.imm : ry_val;

    rc16_alu #(.W(W)) u_alu (.aop(dec.aop), .a(rx_val), .b(alu_b), .y(alu_y));

    assign eff_addr = ry_val + dec.imm;
    assign pc_inc   = pc_q + W'(2);
    assign br_tgt   = pc_inc + {dec.imm[W-2:0], 1'b0};
    assign jmp_tgt  = {{(W-13){1'b0}}, ir_q[11:0], 1'b0};

    always_comb begin
        if (dec.jmp)                       pc_exec = jmp_tgt;
        else if (dec.bez && rx_val == '0)  pc_exec = br_tgt;
        else                               pc_exec = pc_inc;
    end

    assign rf_we = (state_q == ST_EXEC && dec.wr) || (state_q == ST_WBACK);
    assign rf_wd = (state_q == ST_WBACK) ? mdr_q : alu_y;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FETCH;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH: if (imem_ack) state_d = ST_EXEC;
            ST_EXEC:  state_d = (dec.ld || dec.st) ? ST_MEM : ST_FETCH;
            ST_MEM:   if (dmem_ack) state_d = dec.ld ? ST_WBACK : ST_FETCH;
            ST_WBACK: state_d = ST_FETCH;
            default:  state_d = ST_FETCH;
        endcase
    end

    // outputs
    always_comb begin
        imem_req   = (state_q == ST_FETCH);
        imem_addr  = pc_q;
        dmem_req   = (state_q == ST_MEM);
        dmem_we    = (state_q == ST_MEM) && dec.st;
        dmem_addr  = eff_addr;
        dmem_wdata = rx_val;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q  <= '0;
            ir_q  <= '0;
            mdr_q <= '0;
        end else begin
            unique case (state_q)
                ST_FETCH: if (imem_ack) ir_q <= imem_rdata;
                ST_EXEC:  if (!(dec.ld || dec.st)) pc_q <= pc_exec;
                ST_MEM:   if (dmem_ack) begin
                              mdr_q <= dmem_rdata;
                              if (dec.st) pc_q <= pc_inc;
                          end
                ST_WBACK: pc_q <= pc_inc;
                default:  pc_q <= pc_q;
            endcase
        end
    end
endmodule

// File: rtl/rc16_core_chk.sv
module rc16_core_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         imem_req,
    input logic [W-1:0] imem_addr,
    input logic         imem_ack,
    input logic         dmem_req,
    input logic         dmem_we,
    input logic [W-1:0] dmem_addr,
    input logic [W-1:0] dmem_wdata,
    input logic         dmem_ack
);
    AST_IMEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        imem_req && !imem_ack |=> imem_req && $stable(imem_addr)); // R2

    AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        !(imem_req && dmem_req)); // R2

    AST_DMEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_req && !dmem_ack |=> dmem_req && $stable(dmem_addr)
                                  && $stable(dmem_we) && $stable(dmem_wdata)); // R6

    AST_LOAD_WBACK: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_req && dmem_ack && !dmem_we |=> !imem_req ##1 imem_req); // R5

    AST_STORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_req && dmem_ack && dmem_we |=> imem_req); // R5

    AST_PC_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        imem_req |-> !imem_addr[0]); // R10
endmodule

bind rc16_core rc16_core_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .imem_req(imem_req), .imem_addr(imem_addr), .imem_ack(imem_ack),
    .dmem_req(dmem_req), .dmem_we(dmem_we), .dmem_addr(dmem_addr),
    .dmem_wdata(dmem_wdata), .dmem_ack(dmem_ack)
);

// File: tb/tb_rc16_core.sv
module tb_rc16_core;
    localparam int CLK_PERIOD = 10;
    localparam int IMB = 1024;
    localparam int DMB = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        imem_req, imem_ack = 1'b0;
    logic [15:0] imem_addr, imem_rdata = '0;
    logic        dmem_req, dmem_we, dmem_ack = 1'b0;
    logic [15:0] dmem_addr, dmem_wdata, dmem_rdata = '0;

    rc16_core dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [7:0]  imem [IMB];
    logic [7:0]  dmem [DMB];
    logic [7:0]  mdm  [DMB];
    logic [15:0] mreg [8];
    logic [15:0] mpc, halt_pc;
    int          last_op;
    logic        es_v;
    logic [15:0] es_a, es_d;
    logic [15:0] log_a [32];
    logic [15:0] log_d [32];
    int          n_log, n_chk, n_fail;
    logic        done, ibusy, dbusy;
    logic [15:0] ia0, da0, dd0;
    int          iwait, dwait;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] encA(int op, int rx, int ry, logic [5:0] i6);
        return {4'(op), 3'(rx), 3'(ry), i6};
    endfunction
    function automatic logic [15:0] encB(int op, int rx, logic [8:0] i9);
        return {4'(op), 3'(rx), i9};
    endfunction
    function automatic logic [15:0] encC(int op, int rx, int ry);
        return {4'(op), 3'(rx), 3'(ry), 6'd0};
    endfunction
    function automatic logic [15:0] encD(int op, int i12);
        return {4'(op), 12'(i12)};
    endfunction

    task automatic put(int idx, logic [15:0] w);
        imem[2*idx]   = w[7:0];
        imem[2*idx+1] = w[15:8];
    endtask

    function automatic logic [15:0] rd_i(logic [15:0] a);
        return {imem[10'(a + 16'd1)], imem[a[9:0]]};
    endfunction

    function automatic string tag_of(int op);
        if (op < 0)        return "R1";
        else if (op == 10) return "R7";
        else if (op == 11) return "R8";
        else if (op >= 12) return "R9";
        else               return "R10";
    endfunction

    // reference instruction-set model
    task automatic model_step();
        logic [15:0] ins, s6, s9, a, nxt;
        int op, rx, ry;
        ins = rd_i(mpc);
        op  = int'(ins[15:12]);
        rx  = int'(ins[11:9]);
        ry  = int'(ins[8:6]);
        s6  = {{10{ins[5]}}, ins[5:0]};
        s9  = {{7{ins[8]}}, ins[8:0]};
        nxt = mpc + 16'd2;
        a   = mreg[ry] + s6;
        case (op)
            0:  mreg[rx] = mreg[ry];
            1:  mreg[rx] = mreg[rx] + mreg[ry];
            2:  mreg[rx] = mreg[rx] - mreg[ry];
            3:  mreg[rx] = mreg[rx] | mreg[ry];
            4:  mreg[rx] = mreg[rx] & mreg[ry];
            5:  mreg[rx] = s9;
            6:  mreg[rx] = mreg[rx] + s9;
            7:  mreg[rx] = mreg[rx] - s9;
            8:  mreg[rx] = {mdm[8'(a + 16'd1)], mdm[a[7:0]]};
            9:  begin
                    es_v = 1'b1; es_a = a; es_d = mreg[rx];
                    mdm[a[7:0]]         = mreg[rx][7:0];
                    mdm[8'(a + 16'd1)]  = mreg[rx][15:8];
                end
            10: if (mreg[rx] == 16'd0) nxt = mpc + 16'd2 + {s6[14:0], 1'b0};
            11: nxt = {3'b000, ins[11:0], 1'b0};
            default: ;
        endcase
        mpc     = nxt;
        last_op = op;
    endtask

    // memory responders, acting on the falling edge
    always @(negedge clk) begin
        if (!rst_n) begin
            imem_ack = 1'b0; dmem_ack = 1'b0; ibusy = 1'b0; dbusy = 1'b0;
        end else begin
            if (imem_ack) begin
                imem_ack = 1'b0; ibusy = 1'b0;
            end else if (imem_req) begin
                if (!ibusy) begin ibusy = 1'b1; ia0 = imem_addr; iwait = int'($urandom % 3); end
                if (iwait == 0) begin
                    chk(imem_addr == ia0, "R2", "fetch address held", 32'(imem_addr), 32'(ia0));
                    if (!done) chk(imem_addr == mpc, tag_of(last_op), "fetch address",
                                   32'(imem_addr), 32'(mpc));
                    imem_rdata = rd_i(imem_addr);
                    imem_ack   = 1'b1;
                    if (imem_addr == halt_pc && mpc == halt_pc) done = 1'b1;
                    else if (!done) model_step();
                end else iwait--;
            end
            if (dmem_ack) begin
                dmem_ack = 1'b0; dbusy = 1'b0;
            end else if (dmem_req) begin
                if (!dbusy) begin dbusy = 1'b1; da0 = dmem_addr; dd0 = dmem_wdata;
                                  dwait = int'($urandom % 4); end
                if (dwait == 0) begin
                    chk(dmem_addr == da0 && dmem_wdata == dd0, "R6", "data request held",
                        {dmem_addr, dmem_wdata}, {da0, dd0});
                    if (dmem_we) begin
                        chk(es_v, "R5", "store expected", 32'(es_v), 32'd1);
                        chk(dmem_addr == es_a, "R5", "store address", 32'(dmem_addr), 32'(es_a));
                        chk(dmem_wdata == es_d, "R5", "store data", 32'(dmem_wdata), 32'(es_d));
                        dmem[dmem_addr[7:0]]        = dmem_wdata[7:0];
                        dmem[8'(dmem_addr + 16'd1)] = dmem_wdata[15:8];
                        if (n_log < 32) begin log_a[n_log] = dmem_addr; log_d[n_log] = dmem_wdata; end
                        n_log++;
                        es_v = 1'b0;
                    end else begin
                        dmem_rdata = {dmem[8'(dmem_addr + 16'd1)], dmem[dmem_addr[7:0]]};
                    end
                    dmem_ack = 1'b1;
                end else dwait--;
            end
        end
    end

    task automatic run(input logic [15:0] hpc);
        int cyc;
        @(negedge clk);
        rst_n = 1'b0;
        halt_pc = hpc; done = 1'b0; es_v = 1'b0; n_log = 0; mpc = '0; last_op = -1;
        for (int i = 0; i < 8; i++) mreg[i] = '0;
        for (int i = 0; i < DMB; i++) mdm[i] = dmem[i];
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk(imem_req && !dmem_req && imem_addr == 16'd0, "R1", "reset fetch state",
            {15'd0, imem_req, imem_addr}, {15'd0, 1'b1, 16'd0});
        rst_n = 1'b1;
        cyc = 0;
        while (!done && cyc < 20000) begin @(posedge clk); cyc++; end
        chk(done, "R10", "watchdog: halt address reached", 32'(done), 32'd1);
        chk(!es_v, "R5", "pending store completed", 32'(es_v), 32'd0);
    endtask

    task automatic expect_log(int i, logic [15:0] a, logic [15:0] d, string req);
        chk(log_a[i] == a && log_d[i] == d, req, $sformatf("store #%0d", i),
            {log_a[i], log_d[i]}, {a, d});
    endtask

    initial begin
        n_chk = 0; n_fail = 0; done = 1'b0; halt_pc = '1; mpc = '0; last_op = -1;
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < IMB; i++) imem[i] = 8'h00;
        for (int i = 0; i < DMB; i++) dmem[i] = 8'h00;
        dmem[8'h20] = 8'h34; dmem[8'h21] = 8'h12;
        dmem[8'h31] = 8'hCD; dmem[8'h32] = 8'hAB;

        // directed program
        put(0,  encB(5, 1, 9'h1FF));
        put(1,  encA(9, 1, 0, 6'd4));
        put(2,  encB(5, 2, 9'd5));
        put(3,  encB(7, 2, 9'd7));
        put(4,  encA(9, 2, 0, 6'd6));
        put(5,  encB(5, 3, 9'h55));
        put(6,  encB(5, 4, 9'h0F));
        put(7,  encC(4, 3, 4));
        put(8,  encC(1, 3, 4));
        put(9,  encA(9, 3, 0, 6'd8));
        put(10, encB(5, 6, 9'h30));
        put(11, encA(8, 5, 6, 6'd1));
        put(12, encA(9, 5, 0, 6'd10));
        put(13, encA(8, 5, 6, 6'h30));
        put(14, encA(9, 5, 6, 6'h3C));
        put(15, encA(10, 0, 1, 6'd1));
        put(16, encB(5, 2, 9'h77));
        put(17, encA(9, 2, 0, 6'd12));
        put(18, encA(10, 1, 0, 6'd1));
        put(19, encB(5, 2, 9'h11));
        put(20, encA(9, 2, 0, 6'd14));
        put(21, 16'hC000);
        put(22, 16'hFFFF);
        put(23, encA(9, 2, 0, 6'd16));
        put(24, encD(11, 30));
        for (int i = 25; i < 30; i++) put(i, encB(5, 2, 9'h22));
        put(30, encA(9, 2, 0, 6'd18));
        put(31, encC(0, 7, 1));
        put(32, encC(2, 7, 4));
        put(33, encC(3, 7, 3));
        put(34, encA(9, 7, 0, 6'd20));
        put(35, encD(11, 35));
        run(16'd70);
        chk(n_log == 10, "R5", "directed store count", 32'(n_log), 32'd10);
        expect_log(0, 16'h0004, 16'hFFFF, "R4");
        expect_log(1, 16'h0006, 16'hFFFE, "R4");
        expect_log(2, 16'h0008, 16'h0014, "R3");
        expect_log(3, 16'h000A, 16'hABCD, "R5");
        expect_log(4, 16'h002C, 16'h1234, "R5");
        expect_log(5, 16'h000C, 16'hFFFE, "R7");
        expect_log(6, 16'h000E, 16'h0011, "R7");
        expect_log(7, 16'h0010, 16'h0011, "R9");
        expect_log(8, 16'h0012, 16'h0011, "R8");
        expect_log(9, 16'h0014, 16'hFFF4, "R3");

        // random programs, each ending with a dump of all registers
        for (int p = 0; p < 4; p++) begin
            for (int i = 0; i < IMB; i++) imem[i] = 8'h00;
            for (int i = 0; i < DMB; i++) dmem[i] = 8'($urandom);
            for (int i = 0; i < 40; i++) begin
                logic [15:0] w;
                int r;
                r = int'($urandom % 16);
                if (r == 11) r = 1;
                w = {4'(r), 12'($urandom)};
                if (r == 10) w[5:0] = 6'($urandom % 4);
                put(i, w);
            end
            for (int i = 0; i < 8; i++) put(40 + i, encA(9, i, 0, 6'(2 * i)));
            put(48, encD(11, 48));
            run(16'd96);
            chk(n_log >= 8, "R3", "register dump stores seen", 32'(n_log), 32'd8);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        n_chk++; n_fail++;
        $display("FAIL R10 global watchdog: actual %h expected %h", 32'd0, 32'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule